// File: doc/BRIEF.md
# Mode-Selectable Ratio Clock Divider

This block derives a family of related clocks from a single master clock that runs at twice the selected processor frequency. It produces a processor clock, a half-rate memory reference, a mid-rate (66 MHz-class) clock, a bus clock at PCI rate and a slow interrupt-controller clock. It also controls the enables of two pass-through outputs: a USB-rate clock that comes from an external synthesizer and a reference clock. Every output is a pair made of a data bit and an output-enable bit. A pad ring turns each pair into a tri-state driver, so high-impedance behaviour can be observed in simulation.

A three-bit select chooses the operating mode. Two modes use the fast ratio set, in which the processor clock is 133 MHz-class. Two modes use the slow ratio set, in which the processor clock is 100 MHz-class and some ratios are odd. A test mode feeds an external test clock into the master clock input and divides it using the fast ratio set. One mode switches every output off. Two codes are reserved. A change of select restarts all dividers together, so every divided clock rises again on one common master edge.

Top module: `clk_ratio_gen`

## Requirements
- R1: Reset is synchronous and active low. While it is asserted, all five divided data outputs are low. On the first master rising edge after release, all divided outputs of a running mode rise together.
- R2: In every running mode (`sel_i` = 010, 011, 100, 110, 111), the processor output toggles on every master rising edge, giving a period of 2 master cycles.
- R3: Fast set (`sel_i[2]`=1, codes 110 and 111). Periods in master cycles are: memory reference 4, mid-rate 4, bus 8, interrupt controller 16.
- R4: Slow set (`sel_i[2]`=0, codes 010 and 011). Periods in master cycles are: memory reference 4, mid-rate 3, bus 6, interrupt controller 12.
- R5: Every divided output is high for exactly half its period. The period-3 mid-rate clock is high for 1.5 master cycles, and its fall is placed on a master falling edge.
- R6: Every bus-clock rising edge coincides with a rising edge of the processor clock and of the mid-rate clock. Every interrupt-controller rising edge coincides with a rising edge of the bus clock and of the memory reference.
- R7: When `sel_i` differs from the mode registered on the previous edge, the next master edge clears every divider. After that edge all five divided outputs are low. On the following edge they all rise in the new ratios.
- R8: Codes 000, 001 and 101 deassert all seven output enables and drive all seven data outputs low.
- R9: Codes 010 and 110 hold the USB-rate output off, with enable and data both low. The other six outputs keep running.
- R10: Codes 011 and 111 enable the USB-rate output, which passes `usb_in`, and the reference output, which passes `ref_in`.
- R11: Code 100 (test) uses the fast ratios on the test clock applied at `clk`. In this mode the reference output follows `clk` itself and the USB-rate output copies the processor output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at twice the processor rate; carries the test clock in test mode |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 3 | Mode select; bit 2 picks the fast ratio set, bits 1:0 the function |
| ref_in | input | 1 | Reference clock passed through in normal modes |
| usb_in | input | 1 | USB-rate clock from the external synthesizer |
| cpu_clk_o | output | 1 | Processor clock data |
| cpu_clk_oe | output | 1 | Processor clock enable |
| mem_clk_o | output | 1 | Half-rate memory reference data |
| mem_clk_oe | output | 1 | Memory reference enable |
| mid_clk_o | output | 1 | Mid-rate clock data |
| mid_clk_oe | output | 1 | Mid-rate clock enable |
| pci_clk_o | output | 1 | Bus clock data |
| pci_clk_oe | output | 1 | Bus clock enable |
| irq_clk_o | output | 1 | Interrupt-controller clock data |
| irq_clk_oe | output | 1 | Interrupt-controller clock enable |
| usb_clk_o | output | 1 | USB-rate output data |
| usb_clk_oe | output | 1 | USB-rate output enable |
| ref_clk_o | output | 1 | Reference output data |
| ref_clk_oe | output | 1 | Reference output enable |

## Verification
The following properties are checked on every cycle: the processor clock toggles each edge, the rising edges of the slower clocks nest inside the faster ones, all counters reload together, everything is low after a restart edge, and the enable and pass-through pattern matches each select code. Only the bench scenarios show the exact periods of each ratio set and the 1.5-cycle high phase of the odd divider, because that phase is visible only when the master falling edge is sampled. The same applies to the waveform of the reference output in test mode.

// File: rtl/clk_ratio_pkg.sv
`timescale 1ns/1ps
package clk_ratio_pkg;

  localparam int DIVW    = 8;
  localparam int NUM_DIV = 5;

  localparam int CH_CPU = 0;
  localparam int CH_MEM = 1;
  localparam int CH_MID = 2;
  localparam int CH_PCI = 3;
  localparam int CH_IRQ = 4;

  typedef logic [DIVW-1:0] div_t;

  typedef struct packed {
    logic run;
    logic slow;
    logic test;
    logic usb_en;
  } ratio_mode_t;

  // select code -> operating configuration
  function automatic ratio_mode_t decode_mode(input logic [2:0] sel);
    ratio_mode_t m;
    m = '0;
    case (sel)
      3'b010: begin m.run = 1'b1; m.slow = 1'b1; end
      3'b011: begin m.run = 1'b1; m.slow = 1'b1; m.usb_en = 1'b1; end
      3'b100: begin m.run = 1'b1; m.test = 1'b1; end
      3'b110: begin m.run = 1'b1; end
      3'b111: begin m.run = 1'b1; m.usb_en = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  // down-count value at or above which the output is high
  function automatic div_t hi_threshold(input div_t period);
    return period - (period >> 1);
  endfunction

endpackage

// File: rtl/clk_ratio_div.sv
`timescale 1ns/1ps
module clk_ratio_div
  import clk_ratio_pkg::*;
#(
  parameter int unsigned P_FAST = 4,
  parameter int unsigned P_SLOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slow,
  output logic wave_o,
  output logic reload_o
);

  localparam bit HAS_ODD = ((P_FAST % 2) == 1) || ((P_SLOW % 2) == 1);

  div_t period;
  div_t cnt_q;
  div_t cnt_nxt;
  logic hi_q;
  logic hi_nxt;

  assign period   = slow ? div_t'(P_SLOW) : div_t'(P_FAST);
  assign reload_o = (cnt_q == '0);
  assign cnt_nxt  = reload_o ? (period - div_t'(1)) : (cnt_q - div_t'(1));
  assign hi_nxt   = (cnt_nxt >= hi_threshold(period));

  // zero is the parked state: the next edge reloads and raises the output
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      hi_q  <= hi_nxt;
    end
  end

  generate
    if (HAS_ODD) begin : g_odd
      logic hi_n_q;
      // half-cycle stretch so an odd period keeps an even duty
      always_ff @(negedge clk) begin
        if (!rst_n) hi_n_q <= 1'b0;
        else        hi_n_q <= hi_q;
      end
      assign wave_o = hi_q | (hi_n_q & period[0]);
    end else begin : g_even
      assign wave_o = hi_q;
    end
  endgenerate

endmodule

// File: rtl/clk_ratio_mode.sv
`timescale 1ns/1ps
module clk_ratio_mode
  import clk_ratio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel_i,
  output logic [2:0]  mode_q,
  output logic        clr_o,
  output ratio_mode_t cfg_o
);

  always_ff @(posedge clk) begin
    mode_q <= sel_i;
  end

  assign clr_o = rst_n && (sel_i != mode_q);
  assign cfg_o = decode_mode(mode_q);

endmodule

// File: rtl/clk_ratio_gen.sv
`timescale 1ns/1ps
module clk_ratio_gen
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CPU_DIV      = 2,
  parameter int unsigned MEM_DIV      = 4,
  parameter int unsigned MID_DIV_FAST = 4,
  parameter int unsigned MID_DIV_SLOW = 3,
  parameter int unsigned PCI_DIV_FAST = 8,
  parameter int unsigned PCI_DIV_SLOW = 6,
  parameter int unsigned IRQ_DIV_FAST = 16,
  parameter int unsigned IRQ_DIV_SLOW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       ref_in,
  input  logic       usb_in,
  output logic       cpu_clk_o,
  output logic       cpu_clk_oe,
  output logic       mem_clk_o,
  output logic       mem_clk_oe,
  output logic       mid_clk_o,
  output logic       mid_clk_oe,
  output logic       pci_clk_o,
  output logic       pci_clk_oe,
  output logic       irq_clk_o,
  output logic       irq_clk_oe,
  output logic       usb_clk_o,
  output logic       usb_clk_oe,
  output logic       ref_clk_o,
  output logic       ref_clk_oe
);

  localparam int unsigned FAST_TAB [NUM_DIV] =
    '{CPU_DIV, MEM_DIV, MID_DIV_FAST, PCI_DIV_FAST, IRQ_DIV_FAST};
  localparam int unsigned SLOW_TAB [NUM_DIV] =
    '{CPU_DIV, MEM_DIV, MID_DIV_SLOW, PCI_DIV_SLOW, IRQ_DIV_SLOW};

  logic [2:0]         mode_q;
  logic               mode_clr;
  ratio_mode_t        cfg;
  logic [NUM_DIV-1:0] div_wave;
  logic [NUM_DIV-1:0] div_reload;
  logic               run;

  clk_ratio_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .mode_q (mode_q),
    .clr_o  (mode_clr),
    .cfg_o  (cfg)
  );

  generate
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      clk_ratio_div #(
        .P_FAST (FAST_TAB[g]),
        .P_SLOW (SLOW_TAB[g])
      ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mode_clr),
        .slow     (cfg.slow),
        .wave_o   (div_wave[g]),
        .reload_o (div_reload[g])
      );
    end
  endgenerate

  assign run = cfg.run;

  assign cpu_clk_o  = run & div_wave[CH_CPU];
  assign cpu_clk_oe = run;
  assign mem_clk_o  = run & div_wave[CH_MEM];
  assign mem_clk_oe = run;
  assign mid_clk_o  = run & div_wave[CH_MID];
  assign mid_clk_oe = run;
  assign pci_clk_o  = run & div_wave[CH_PCI];
  assign pci_clk_oe = run;
  assign irq_clk_o  = run & div_wave[CH_IRQ];
  assign irq_clk_oe = run;

  assign usb_clk_oe = run & (cfg.usb_en | cfg.test);
  assign usb_clk_o  = usb_clk_oe & (cfg.test ? div_wave[CH_CPU] : usb_in);

  assign ref_clk_oe = run;
  assign ref_clk_o  = run & (cfg.test ? clk : ref_in);

endmodule

// File: rtl/clk_ratio_gen_chk.sv
`timescale 1ns/1ps
module clk_ratio_gen_chk
  import clk_ratio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         sel_i,
  input logic               ref_in,
  input logic               usb_in,
  input logic               clr_w,
  input logic [NUM_DIV-1:0] reload_w,
  input logic               cpu_clk_o,
  input logic               cpu_clk_oe,
  input logic               mem_clk_o,
  input logic               mem_clk_oe,
  input logic               mid_clk_o,
  input logic               mid_clk_oe,
  input logic               pci_clk_o,
  input logic               pci_clk_oe,
  input logic               irq_clk_o,
  input logic               irq_clk_oe,
  input logic               usb_clk_o,
  input logic               usb_clk_oe,
  input logic               ref_clk_o,
  input logic               ref_clk_oe
);

  logic off_sel;
  logic any_oe;
  logic any_div_hi;

  assign off_sel    = (sel_i == 3'b000) || (sel_i == 3'b001) || (sel_i == 3'b101);
  assign any_oe     = cpu_clk_oe | mem_clk_oe | mid_clk_oe | pci_clk_oe |
                      irq_clk_oe | usb_clk_oe | ref_clk_oe;
  assign any_div_hi = cpu_clk_o | mem_clk_o | mid_clk_o | pci_clk_o | irq_clk_o;

  a_r2_cpu_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && cpu_clk_oe) |=> (cpu_clk_o != $past(cpu_clk_o)));

  a_r6_pci_nested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk_o) |-> ($rose(cpu_clk_o) && $rose(mid_clk_o)));

  a_r6_irq_nested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_clk_o) |-> ($rose(pci_clk_o) && $rose(mem_clk_o)));

  a_r6_common_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_w[CH_IRQ] |-> (reload_w[CH_PCI] && reload_w[CH_MEM] && reload_w[CH_CPU]));

  a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !any_div_hi);

  a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    off_sel |=> (!any_oe && !any_div_hi && !usb_clk_o && !ref_clk_o));

  a_r9_usb_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == 3'b010) || (sel_i == 3'b110)) |=>
      (!usb_clk_oe && !usb_clk_o && irq_clk_oe && ref_clk_oe));

  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == 3'b011) || (sel_i == 3'b111)) |=>
      (usb_clk_oe && (usb_clk_o == usb_in) && (ref_clk_o == ref_in)));

  a_r11_test_usb: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b100) |=> (usb_clk_oe && (usb_clk_o == cpu_clk_o)));

endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_i      (sel_i),
  .ref_in     (ref_in),
  .usb_in     (usb_in),
  .clr_w      (mode_clr),
  .reload_w   (div_reload),
  .cpu_clk_o  (cpu_clk_o),
  .cpu_clk_oe (cpu_clk_oe),
  .mem_clk_o  (mem_clk_o),
  .mem_clk_oe (mem_clk_oe),
  .mid_clk_o  (mid_clk_o),
  .mid_clk_oe (mid_clk_oe),
  .pci_clk_o  (pci_clk_o),
  .pci_clk_oe (pci_clk_oe),
  .irq_clk_o  (irq_clk_o),
  .irq_clk_oe (irq_clk_oe),
  .usb_clk_o  (usb_clk_o),
  .usb_clk_oe (usb_clk_oe),
  .ref_clk_o  (ref_clk_o),
  .ref_clk_oe (ref_clk_oe)
);

// File: tb/clk_ratio_gen_tb.sv
`timescale 1ns/100ps
module clk_ratio_gen_tb_top;

  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b111;
  logic       ref_in = 1'b0;
  logic       usb_in = 1'b0;
  logic       cpu_o, cpu_oe, mem_o, mem_oe, mid_o, mid_oe, pci_o, pci_oe;
  logic       irq_o, irq_oe, usb_o, usb_oe, ref_o, ref_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [2:0] cur = 3'b111;

  always #5 clk = ~clk;

  clk_ratio_gen dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .ref_in(ref_in), .usb_in(usb_in),
    .cpu_clk_o(cpu_o), .cpu_clk_oe(cpu_oe), .mem_clk_o(mem_o), .mem_clk_oe(mem_oe),
    .mid_clk_o(mid_o), .mid_clk_oe(mid_oe), .pci_clk_o(pci_o), .pci_clk_oe(pci_oe),
    .irq_clk_o(irq_o), .irq_clk_oe(irq_oe), .usb_clk_o(usb_o), .usb_clk_oe(usb_oe),
    .ref_clk_o(ref_o), .ref_clk_oe(ref_oe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_off(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b001) || (s == 3'b101);
  endfunction

  // period in master cycles for divided channel ch (0 cpu .. 4 irq)
  function automatic int period_of(input int ch, input logic [2:0] s);
    bit slow = (s[2] == 1'b0);
    case (ch)
      0: return 2;
      1: return 4;
      2: return slow ? 3 : 4;
      3: return slow ? 6 : 8;
      default: return slow ? 12 : 16;
    endcase
  endfunction

  // expected {oe,data} at half-step h after the common rising edge
  function automatic logic [1:0] expect_of(input int ch, input logic [2:0] s, input int h,
                                           input logic u, input logic r);
    bit tst = (s == 3'b100);
    int p;
    if (is_off(s)) return 2'b00;
    if (ch == 5) begin
      if (s == 3'b010 || s == 3'b110) return 2'b00;
      if (tst) return {1'b1, ((h % 4) < 2)};
      return {1'b1, u};
    end
    if (ch == 6) return tst ? {1'b1, ((h % 2) == 0)} : {1'b1, r};
    p = period_of(ch, s);
    return {1'b1, ((h % (2 * p)) < p)};
  endfunction

  function automatic logic [1:0] actual_of(input int ch);
    case (ch)
      0: return {cpu_oe, cpu_o};
      1: return {mem_oe, mem_o};
      2: return {mid_oe, mid_o};
      3: return {pci_oe, pci_o};
      4: return {irq_oe, irq_o};
      5: return {usb_oe, usb_o};
      default: return {ref_oe, ref_o};
    endcase
  endfunction

  function automatic string tag_of(input int ch, input logic [2:0] s);
    if (is_off(s)) return "R8";
    if (s == 3'b100) return (ch == 0) ? "R2" : "R11";
    if (ch == 0) return "R2";
    if (ch <= 4) return (s[2] == 1'b0) ? "R4" : "R3";
    if (ch == 5 && (s == 3'b010 || s == 3'b110)) return "R9";
    return "R10";
  endfunction

  // entered right at the common rising edge
  task automatic run_window(input logic [2:0] s, input string align_tag);
    int bad [7];
    int first_h [7];
    logic [1:0] first_a [7];
    logic [1:0] first_e [7];
    int mid_hi = 0;
    bit all_hi0 = 0;
    for (int c = 0; c < 7; c++) begin bad[c] = 0; first_h[c] = -1; end
    #2.5;
    for (int h = 0; h < WIN; h++) begin
      if (h == 0) all_hi0 = cpu_o & mem_o & mid_o & pci_o & irq_o;
      if (h < 2 * period_of(2, s) && mid_o) mid_hi++;
      for (int c = 0; c < 7; c++) begin
        logic [1:0] a = actual_of(c);
        logic [1:0] e = expect_of(c, s, h, usb_in, ref_in);
        if (a !== e) begin
          if (bad[c] == 0) begin first_h[c] = h; first_a[c] = a; first_e[c] = e; end
          bad[c]++;
        end
      end
      #5;
    end
    for (int c = 0; c < 7; c++)
      check(bad[c] == 0, tag_of(c, s),
            $sformatf("sel=%b ch%0d h=%0d {oe,data}", s, c, first_h[c]),
            int'(first_a[c]), int'(first_e[c]));
    if (!is_off(s)) begin
      // R5: odd-period mid-rate clock high for exactly half of one period
      check(mid_hi == period_of(2, s), "R5", $sformatf("sel=%b mid high half-steps", s),
            mid_hi, period_of(2, s));
      check(all_hi0 == 1'b1, align_tag, $sformatf("sel=%b common rise", s),
            int'(all_hi0), 1);
    end
  endtask

  task automatic run_scn(input logic [2:0] s_in);
    logic [2:0] s = s_in;
    logic lo;
    if (s == cur) s = s ^ 3'b010;
    @(posedge clk); #1;
    sel = s;
    usb_in = 1'($urandom);
    ref_in = 1'($urandom);
    @(posedge clk);   // restart edge
    #7.5;
    lo = !(cpu_o | mem_o | mid_o | pci_o | irq_o);
    check(lo == 1'b1, "R7", $sformatf("sel=%b low after restart", s), int'(lo), 1);
    @(posedge clk);   // common rise
    run_window(s, "R6");
    cur = s;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lo;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_c10c);
    repeat (4) @(posedge clk);
    #2.5;
    lo = !(cpu_o | mem_o | mid_o | pci_o | irq_o);
    check(lo == 1'b1, "R1", "outputs low in reset", int'(lo), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk);
    run_window(3'b111, "R1");
    cur = 3'b111;
    // directed corner cases
    run_scn(3'b011);
    run_scn(3'b100);
    run_scn(3'b000);
    run_scn(3'b110);
    run_scn(3'b010);
    run_scn(3'b001);
    run_scn(3'b111);
    run_scn(3'b101);
    run_scn(3'b011);
    run_scn(3'b110);
    // constrained random sequence
    for (int i = 0; i < 12; i++) run_scn(3'($urandom));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule